// File: doc/BRIEF.md
# Current-Sense ADC Register Peripheral

This block is the register face of a 16-bit current-measurement converter. It sits on a simple byte-wide register bus with an address, write data, registered read data, and separate read and write strobes. Software identifies the block through fixed read-only bytes. It stores an operating-mode byte and picks one of several sense channels. It then switches the converter on and starts a conversion. Software either polls a two-bit status field or waits for a rising-edge end-of-conversion interrupt.

A conversion runs for a fixed number of clock cycles, set by a parameter so that short simulation runs are possible. The converted code is taken from a per-channel sample input port, which stands in for the analog front end and the filter. At completion the block latches that code into a two-byte result, sets the status flags and pulses the interrupt. A reset-control byte can only be written right after a one-shot unlock key. This keeps software that runs away from changing it.

Top module: `isense_adc_regs`

## Requirements
- R1: Reads of the identification bytes return 0x01 at address 0x01, 0x08 at 0x04 and 0x03 at 0x05. Writes to these addresses change nothing.
- R2: Bit 7 of the enable byte at 0x46 is the converter enable. Any write stores bit 7 only, so the byte reads back as 0x80 or 0x00.
- R3: The channel byte at 0x48 accepts only codes 0, 1, 3, 5 and 6. A write with any other value is dropped and the previous code stays.
- R4: A write with bit 7 set to the request byte at 0x52 while enabled and idle starts a conversion. The status byte at 0x08 (bit 1 request-pending, bit 0 end-of-conversion) then reads 0x02. A request while disabled is ignored.
- R5: A conversion ends exactly CONV_CYCLES clock edges after the request write. The status then reads 0x01, and the result holds the sample slot of the channel that was selected at request time, with the low byte at 0x60 and the high byte at 0x61.
- R6: The interrupt output goes high for exactly one clock cycle when a conversion completes.
- R7: Writing 0 to the enable byte aborts a running conversion. Request-pending clears, no interrupt follows, and the result keeps its old value.
- R8: Writing 0xA5 to the key byte at 0xD0 unlocks exactly one following bus access. A write to the reset-control byte at 0xDA takes effect only as that access. Any other write to 0xDA is dropped.
- R9: After reset the status, enable, channel, result and reset-control bytes read 0x00, and the interrupt and read data are low.
- R10: The mode byte at 0x40 is a full 8-bit read/write register. Unmapped addresses read 0x00.
- R11: A request written while a conversion is already pending is ignored and does not restart the conversion timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe; data appears on rdata_o after the edge |
| rdata_o | output | 8 | Registered read data |
| sample_i | input | CH_SLOTS*16 | Converted code per channel slot, slot k at bits [16k+15:16k] |
| eoc_irq_o | output | 1 | End-of-conversion pulse |

## Verification
A wrong internal state would show up mostly in two places: the status byte and the interrupt timing. A timer that is off by one moves the interrupt by one edge. The bench counts edges from the request write and checks this exactly. A conversion-pending flag that is not cleared by an abort or a disable shows up at the next status read. It also shows up as an interrupt that should not come, within CONV_CYCLES edges. An unlock flag that lasts too long shows up at once, as a reset-control value that changes when it should have stayed the same. A channel that is latched at the wrong moment shows up as a result byte from the wrong sample slot.

// File: rtl/isense_pkg.sv
package isense_pkg;
  localparam logic [7:0] A_REV    = 8'h01;
  localparam logic [7:0] A_TYPE   = 8'h04;
  localparam logic [7:0] A_SUBT   = 8'h05;
  localparam logic [7:0] A_STAT   = 8'h08;
  localparam logic [7:0] A_MODE   = 8'h40;
  localparam logic [7:0] A_EN     = 8'h46;
  localparam logic [7:0] A_CHAN   = 8'h48;
  localparam logic [7:0] A_REQ    = 8'h52;
  localparam logic [7:0] A_RES_LO = 8'h60;
  localparam logic [7:0] A_RES_HI = 8'h61;
  localparam logic [7:0] A_KEY    = 8'hD0;
  localparam logic [7:0] A_RSTCTL = 8'hDA;

  localparam logic [7:0] ID_REV   = 8'h01;
  localparam logic [7:0] ID_TYPE  = 8'h08;
  localparam logic [7:0] ID_SUBT  = 8'h03;
  localparam logic [7:0] UNLOCK_KEY = 8'hA5;

  function automatic logic chan_ok(input logic [7:0] c);
    return c inside {8'd0, 8'd1, 8'd3, 8'd5, 8'd6};
  endfunction
endpackage

// File: rtl/isense_conv_ctrl.sv
module isense_conv_ctrl #(
  parameter int CONV_CYCLES = 200,
  parameter int RES_W       = 16,
  parameter int CH_SLOTS    = 8,
  localparam int CH_W  = $clog2(CH_SLOTS),
  localparam int CNT_W = $clog2(CONV_CYCLES + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      abort_i,
  input  logic [CH_W-1:0]           chan_i,
  input  logic [CH_SLOTS*RES_W-1:0] sample_i,
  output logic                      pending_o,
  output logic                      eoc_o,
  output logic                      irq_o,
  output logic [RES_W-1:0]          result_o
);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o <= 1'b0;
      eoc_o     <= 1'b0;
      irq_o     <= 1'b0;
      result_o  <= '0;
      cnt_q     <= '0;
      chan_q    <= '0;
    end else begin
      irq_o <= 1'b0;
      if (abort_i) begin
        pending_o <= 1'b0;
      end else if (start_i && !pending_o) begin
        pending_o <= 1'b1;
        eoc_o     <= 1'b0;
        cnt_q     <= CNT_LOAD;
        chan_q    <= chan_i;   // channel frozen at request
      end else if (pending_o) begin
        if (cnt_q == '0) begin
          pending_o <= 1'b0;
          eoc_o     <= 1'b1;
          irq_o     <= 1'b1;
          result_o  <= sample_i[chan_q*RES_W +: RES_W];
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/isense_key_guard.sv
module isense_key_guard #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              access_i,
  input  logic              key_wr_i,
  input  logic              prot_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              unlocked_o,
  output logic [DATA_W-1:0] prot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_o <= 1'b0;
      prot_o     <= '0;
    end else begin
      if (prot_wr_i && unlocked_o) prot_o <= wdata_i;
      // one-shot: any access other than a correct key write consumes it
      if (key_wr_i && wdata_i == DATA_W'(isense_pkg::UNLOCK_KEY))
        unlocked_o <= 1'b1;
      else if (access_i)
        unlocked_o <= 1'b0;
    end
  end
endmodule

// File: rtl/isense_adc_regs.sv
module isense_adc_regs #(
  parameter int CONV_CYCLES = 200,
  parameter int CH_SLOTS    = 8,
  parameter int RES_W       = 16,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  localparam int CH_W = $clog2(CH_SLOTS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      wr_i,
  input  logic                      rd_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic [CH_SLOTS*RES_W-1:0] sample_i,
  output logic                      eoc_irq_o
);
  import isense_pkg::*;

  logic              en_q;
  logic [DATA_W-1:0] mode_q;
  logic [CH_W-1:0]   chan_q;
  logic              pending, eoc, unlocked;
  logic [RES_W-1:0]  result;
  logic [DATA_W-1:0] rstctl;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_en, wr_chan, wr_mode, start, abort;

  assign wr_en   = wr_i && addr_i == ADDR_W'(A_EN);
  assign wr_chan = wr_i && addr_i == ADDR_W'(A_CHAN);
  assign wr_mode = wr_i && addr_i == ADDR_W'(A_MODE);
  assign start   = wr_i && addr_i == ADDR_W'(A_REQ) && wdata_i[DATA_W-1] && en_q;
  assign abort   = wr_en && !wdata_i[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= '0;
      chan_q <= '0;
    end else begin
      if (wr_en)   en_q   <= wdata_i[DATA_W-1];
      if (wr_mode) mode_q <= wdata_i;
      if (wr_chan && chan_ok(8'(wdata_i))) chan_q <= wdata_i[CH_W-1:0];
    end
  end

  isense_conv_ctrl #(
    .CONV_CYCLES(CONV_CYCLES), .RES_W(RES_W), .CH_SLOTS(CH_SLOTS)
  ) u_conv (
    .clk_i, .rst_ni,
    .start_i(start), .abort_i(abort), .chan_i(chan_q), .sample_i,
    .pending_o(pending), .eoc_o(eoc), .irq_o(eoc_irq_o), .result_o(result)
  );

  isense_key_guard #(.DATA_W(DATA_W)) u_guard (
    .clk_i, .rst_ni,
    .access_i(wr_i || rd_i),
    .key_wr_i(wr_i && addr_i == ADDR_W'(A_KEY)),
    .prot_wr_i(wr_i && addr_i == ADDR_W'(A_RSTCTL)),
    .wdata_i,
    .unlocked_o(unlocked), .prot_o(rstctl)
  );

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      ADDR_W'(A_REV):    rd_mux = DATA_W'(ID_REV);
      ADDR_W'(A_TYPE):   rd_mux = DATA_W'(ID_TYPE);
      ADDR_W'(A_SUBT):   rd_mux = DATA_W'(ID_SUBT);
      ADDR_W'(A_STAT):   rd_mux = DATA_W'({pending, eoc});
      ADDR_W'(A_MODE):   rd_mux = mode_q;
      ADDR_W'(A_EN):     rd_mux = {en_q, {(DATA_W-1){1'b0}}};
      ADDR_W'(A_CHAN):   rd_mux = DATA_W'(chan_q);
      ADDR_W'(A_REQ):    rd_mux = {pending, {(DATA_W-1){1'b0}}};
      ADDR_W'(A_RES_LO): rd_mux = result[DATA_W-1:0];
      ADDR_W'(A_RES_HI): rd_mux = result[DATA_W +: DATA_W];
      ADDR_W'(A_RSTCTL): rd_mux = rstctl;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/isense_adc_regs_chk.sv
module isense_adc_regs_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int CH_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_i,
  input logic              pending_i,
  input logic              eoc_i,
  input logic              en_i,
  input logic [CH_W-1:0]   chan_i,
  input logic              unlocked_i,
  input logic [DATA_W-1:0] prot_i
);
  AST_ID_TYPE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == ADDR_W'(8'h04) |=> rdata_o == DATA_W'(8'h08)); // R1
  AST_BAD_CHAN_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == ADDR_W'(8'h48) && !isense_pkg::chan_ok(8'(wdata_i)) |=> $stable(chan_i)); // R3
  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pending_i && eoc_i)); // R4
  AST_IRQ_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> eoc_i && !pending_i && $past(pending_i)); // R5
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i); // R6
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !pending_i); // R7
  AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == ADDR_W'(8'hDA) && !unlocked_i |=> $stable(prot_i)); // R8
  AST_UNLOCK_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlocked_i && (rd_i || (wr_i && addr_i != ADDR_W'(8'hD0))) |=> !unlocked_i); // R8
endmodule

bind isense_adc_regs isense_adc_regs_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CH_W(CH_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .irq_i(eoc_irq_o), .pending_i(pending), .eoc_i(eoc), .en_i(en_q),
  .chan_i(chan_q), .unlocked_i(unlocked), .prot_i(rstctl)
);

// File: tb/isense_adc_regs_test.sv
module isense_adc_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int CONV = 16;
  localparam int SLOTS = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        addr = '0;
  logic [7:0]        wdata = '0;
  logic              wr = 1'b0;
  logic              rd = 1'b0;
  logic [7:0]        rdata;
  logic [SLOTS*16-1:0] sample;
  logic              irq;

  int n_chk = 0;
  int n_bad = 0;
  int irq_cnt = 0;
  int irq_wide = 0;
  logic irq_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isense_adc_regs #(.CONV_CYCLES(CONV), .CH_SLOTS(SLOTS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .sample_i(sample), .eoc_irq_o(irq)
  );

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (irq && irq_prev) irq_wide++;
    irq_prev = irq;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bus_rd(a, d);
    check(tag, int'(d), int'(exp));
  endtask

  // returns negedges until irq seen after caller's current point
  task automatic wait_irq(output int k);
    k = 0;
    for (int i = 1; i <= 4*CONV; i++) begin
      @(negedge clk);
      if (irq) begin k = i; break; end
    end
  endtask

  // {tag, is_read, addr, wdata, expected}
  localparam int NV = 20;
  localparam logic [28:0] VEC [NV] = '{
    {4'd1, 1'b1, 8'h01, 8'h00, 8'h01},  // R1 revision
    {4'd1, 1'b1, 8'h04, 8'h00, 8'h08},  // R1 type
    {4'd1, 1'b1, 8'h05, 8'h00, 8'h03},  // R1 subtype
    {4'd1, 1'b0, 8'h04, 8'hFF, 8'h00},
    {4'd1, 1'b1, 8'h04, 8'h00, 8'h08},  // R1 write ignored
    {4'd10,1'b0, 8'h40, 8'h5A, 8'h00},
    {4'd10,1'b1, 8'h40, 8'h00, 8'h5A},  // R10 mode rw
    {4'd10,1'b1, 8'h30, 8'h00, 8'h00},  // R10 unmapped
    {4'd2, 1'b0, 8'h46, 8'hFF, 8'h00},
    {4'd2, 1'b1, 8'h46, 8'h00, 8'h80},  // R2 only bit 7 kept
    {4'd2, 1'b0, 8'h46, 8'h00, 8'h00},
    {4'd2, 1'b1, 8'h46, 8'h00, 8'h00},  // R2 disabled
    {4'd3, 1'b0, 8'h48, 8'h05, 8'h00},
    {4'd3, 1'b1, 8'h48, 8'h00, 8'h05},  // R3 valid code
    {4'd3, 1'b0, 8'h48, 8'h02, 8'h00},
    {4'd3, 1'b1, 8'h48, 8'h00, 8'h05},  // R3 code 2 dropped
    {4'd3, 1'b0, 8'h48, 8'h07, 8'h00},
    {4'd3, 1'b1, 8'h48, 8'h00, 8'h05},  // R3 code 7 dropped
    {4'd3, 1'b0, 8'h48, 8'h01, 8'h00},
    {4'd3, 1'b1, 8'h48, 8'h00, 8'h01}   // R3 code 1
  };

  initial begin
    for (int s = 0; s < SLOTS; s++) sample[s*16 +: 16] = 16'hA000 + 16'(s) * 16'h0111;
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k, c0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 irq", int'(irq), 0);
    check("R9 rdata", int'(rdata), 0);
    rst_n = 1'b1;
    rd_chk("R9 status", 8'h08, 8'h00);
    rd_chk("R9 enable", 8'h46, 8'h00);
    rd_chk("R9 chan", 8'h48, 8'h00);
    rd_chk("R9 res lo", 8'h60, 8'h00);
    rd_chk("R9 res hi", 8'h61, 8'h00);
    rd_chk("R9 rstctl", 8'hDA, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) rd_chk($sformatf("R%0d vec%0d", VEC[i][28:25], i), VEC[i][23:16], VEC[i][7:0]);
      else bus_wr(VEC[i][23:16], VEC[i][15:8]);
    end

    // R5/R6 conversion timing on channel 1
    bus_wr(8'h46, 8'h80);
    bus_wr(8'h52, 8'h80);
    wait_irq(k);
    check("R5 conv cycles", k, CONV);
    @(negedge clk);
    check("R6 irq one cycle", int'(irq), 0);
    rd_chk("R5 status done", 8'h08, 8'h01);
    rd_chk("R5 result lo ch1", 8'h60, 8'h11);
    rd_chk("R5 result hi ch1", 8'h61, 8'hA1);

    // R4 pending status, R11 second request ignored
    bus_wr(8'h52, 8'h80);
    rd_chk("R4 status pending", 8'h08, 8'h02);
    bus_wr(8'h52, 8'h80);
    wait_irq(k);
    check("R11 no restart", k, CONV - 4);

    // R4 request while disabled ignored
    bus_wr(8'h46, 8'h00);
    c0 = irq_cnt;
    bus_wr(8'h52, 8'h80);
    repeat (CONV + 4) @(negedge clk);
    check("R4 no irq disabled", irq_cnt, c0);
    rd_chk("R4 status unchanged", 8'h08, 8'h01);

    // R7 abort on channel 6
    bus_wr(8'h46, 8'h80);
    bus_wr(8'h48, 8'h06);
    bus_wr(8'h52, 8'h80);
    repeat (5) @(negedge clk);
    bus_wr(8'h46, 8'h00);
    c0 = irq_cnt;
    rd_chk("R7 status cleared", 8'h08, 8'h00);
    repeat (CONV + 4) @(negedge clk);
    check("R7 no irq after abort", irq_cnt, c0);
    rd_chk("R7 result kept", 8'h60, 8'h11);

    // R5 channel 6, channel changed mid-conversion
    bus_wr(8'h46, 8'h80);
    bus_wr(8'h52, 8'h80);
    bus_wr(8'h48, 8'h03);
    wait_irq(k);
    check("R5 second conv", k, CONV - 2);
    rd_chk("R5 result lo ch6", 8'h60, 8'h66);
    rd_chk("R5 result hi ch6", 8'h61, 8'hA6);

    // R8 key protection
    bus_wr(8'hDA, 8'h04);
    rd_chk("R8 locked write dropped", 8'hDA, 8'h00);
    bus_wr(8'hD0, 8'hA5);
    bus_wr(8'hDA, 8'h04);
    rd_chk("R8 unlocked write", 8'hDA, 8'h04);
    bus_wr(8'hD0, 8'hA5);
    rd_chk("R8 read consumes", 8'hDA, 8'h04);
    bus_wr(8'hDA, 8'h00);
    rd_chk("R8 after read dropped", 8'hDA, 8'h04);
    bus_wr(8'hD0, 8'hA5);
    bus_wr(8'h40, 8'h11);
    bus_wr(8'hDA, 8'h00);
    rd_chk("R8 other write consumes", 8'hDA, 8'h04);
    bus_wr(8'hD0, 8'h5A);
    bus_wr(8'hDA, 8'h00);
    rd_chk("R8 wrong key", 8'hDA, 8'h04);
    bus_wr(8'hD0, 8'hA5);
    bus_wr(8'hDA, 8'h06);
    rd_chk("R8 rmw write", 8'hDA, 8'h06);

    check("R6 no wide pulse", irq_wide, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule